// File: doc/BRIEF.md
# Drive Run and Trip Supervisor

This block is the run/stop and protection sequencer of a variable-frequency motor drive. It takes a start pushbutton and a stop pushbutton (both already debounced), an overcurrent comparator flag, an input undervoltage flag and a flag from the ramp generator saying the ramped speed reference has decayed to near zero. From these it drives the run request, which releases the speed reference, and the power-stage enable. It also drives three protection commands: inhibit the input rectifier gates, drive every bridge switch on at once, and inhibit commutation gating. A fourth, a bridge gate block, removes all bridge gate drive on undervoltage.

A normal stop only withdraws the run request. The power stage stays enabled while the reference ramps down, and it is released once the low-reference flag appears. An overcurrent trip shorts the DC link through all bridge legs together, so the discharge current is shared between them. Its trip is held for a minimum time, given in microseconds and converted to clock cycles. After that time the fault stays latched until a fresh start press clears it, and that press starts the drive again at once.

Top module: `drv_run_supervisor`

## Requirements
- R1: After reset every output is low and the supervisor is idle.
- R2: In idle with no fault, a start press (a rising edge of `start_btn` with `stop_btn` low) raises `run_req` in the next cycle with `main_en` still low. `main_en` rises one cycle later.
- R3: Once running, `run_req` and `main_en` stay high after `start_btn` is released, and `near_zero_ref` has no effect while running.
- R4: With `stop_btn` high while running, `run_req` falls in the next cycle and `main_en` stays high. When start and stop are both pressed in one cycle, stop wins.
- R5: During the ramp-down, `main_en` stays high until `near_zero_ref` is seen high. All outputs are low in the cycle after that.
- R6: A start press during the ramp-down raises `run_req` again in the next cycle, and `main_en` never drops.
- R7: `oc_trip` high in any state gives, from the next cycle, `rect_inhibit`, `bridge_all_on` and `commut_inhibit` high, and `bridge_block`, `run_req` and `main_en` low.
- R8: `uv_trip` high without `oc_trip` gives, from the next cycle, `rect_inhibit`, `bridge_block` and `commut_inhibit` high, and `bridge_all_on`, `run_req` and `main_en` low.
- R9: Overcurrent outranks undervoltage. When both flags are high together, the overcurrent pattern results. An overcurrent during an undervoltage trip turns it into an overcurrent trip. An undervoltage during an overcurrent trip leaves the overcurrent pattern in place.
- R10: After a fault flag is last seen high at clock edge e, a start press sampled at any edge up to e+HOLD_CYC is ignored and the trip pattern is kept. HOLD_CYC is CLK_HZ/1e6 times HOLD_US.
- R11: A start press sampled at edge e+HOLD_CYC+1 or later, with no fault and `stop_btn` low, clears the trip. In the next cycle the outputs show `run_req` high and everything else low, as in R2.
- R12: With edge-sensitive start (the default), a start button held high continuously from inside the hold time does not clear the trip. A later release and press does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_btn | input | 1 | Start pushbutton, debounced, high when pressed |
| stop_btn | input | 1 | Stop pushbutton, debounced, high when pressed |
| oc_trip | input | 1 | Overcurrent comparator flag |
| uv_trip | input | 1 | Input undervoltage flag |
| near_zero_ref | input | 1 | Ramped reference has decayed to near zero |
| run_req | output | 1 | Releases the speed reference |
| main_en | output | 1 | Keeps the power stage active |
| rect_inhibit | output | 1 | Blocks input rectifier gating |
| bridge_all_on | output | 1 | Gates all bridge switches continuously |
| bridge_block | output | 1 | Removes all bridge gate drive |
| commut_inhibit | output | 1 | Blocks commutation gating |

## Verification
The assertions assume that all inputs are synchronous to `clk` and already debounced. They do not assume any ordering between the fault flags and the buttons, so overlaps such as a start press during a trip or a stop press in the same cycle as a start press are legal. The stimulus changes inputs only on the falling edge. It holds each fault flag for whole cycles. It releases `start_btn` between presses except in the deliberate held-start case. The hold-time sweep places a single start press at every edge offset from one to two past the hold limit. This covers both sides of the acceptance boundary.

// File: rtl/drvsup_pkg.sv
package drvsup_pkg;

   typedef enum logic [2:0] {
      SUP_IDLE  = 3'd0,
      SUP_ARM   = 3'd1,
      SUP_RUN   = 3'd2,
      SUP_RAMP  = 3'd3,
      SUP_TRIP  = 3'd4
   } sup_state_t;

   typedef enum logic {
      FLT_UV = 1'b0,
      FLT_OC = 1'b1
   } flt_kind_t;

   typedef struct packed {
      logic run_req;
      logic main_en;
      logic rect_inhibit;
      logic bridge_all_on;
      logic bridge_block;
      logic commut_inhibit;
   } sup_out_t;

endpackage

// File: rtl/drvsup_press.sv
module drvsup_press #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn,
   output logic press
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic btn_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) btn_q <= 1'b0;
            else        btn_q <= btn;
         end
         assign press = btn & ~btn_q;
      end else begin : g_level
         assign press = btn;
      end
   endgenerate
endmodule

// File: rtl/drvsup_hold_timer.sv
module drvsup_hold_timer #(
   parameter int unsigned HOLD_CYC = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault,
   output logic expired
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("drvsup_hold_timer: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (fault)          cnt <= CW'(HOLD_CYC);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   assert_fault_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !expired);

endmodule

// File: rtl/drvsup_fsm.sv
module drvsup_fsm
   import drvsup_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_press,
   input  logic     stop_lvl,
   input  logic     oc,
   input  logic     uv,
   input  logic     low_ref,
   input  logic     hold_done,
   output sup_out_t outs
);
   sup_state_t state, state_nx;
   flt_kind_t  kind, kind_nx;

   wire go = start_press & ~stop_lvl;

   always_comb begin
      state_nx = state;
      kind_nx  = kind;
      if (oc) begin
         state_nx = SUP_TRIP;
         kind_nx  = FLT_OC;
      end else if (uv) begin
         state_nx = SUP_TRIP;
         kind_nx  = (state == SUP_TRIP && kind == FLT_OC) ? FLT_OC : FLT_UV;
      end else begin
         unique case (state)
            SUP_IDLE: if (go) state_nx = SUP_ARM;
            SUP_ARM:  state_nx = stop_lvl ? SUP_IDLE : SUP_RUN;
            SUP_RUN:  if (stop_lvl) state_nx = SUP_RAMP;
            SUP_RAMP: begin
               if (go)           state_nx = SUP_RUN;
               else if (low_ref) state_nx = SUP_IDLE;
            end
            SUP_TRIP: if (hold_done && go) state_nx = SUP_ARM;
            default:  state_nx = SUP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SUP_IDLE;
         kind  <= FLT_UV;
      end else begin
         state <= state_nx;
         kind  <= kind_nx;
      end
   end

   always_comb begin
      outs = '0;
      unique case (state)
         SUP_ARM:  outs.run_req = 1'b1;
         SUP_RUN: begin
            outs.run_req = 1'b1;
            outs.main_en = 1'b1;
         end
         SUP_RAMP: outs.main_en = 1'b1;
         SUP_TRIP: begin
            outs.rect_inhibit   = 1'b1;
            outs.commut_inhibit = 1'b1;
            outs.bridge_all_on  = (kind == FLT_OC);
            outs.bridge_block   = (kind == FLT_UV);
         end
         default: outs = '0;
      endcase
   end

   assert_start_seeds_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(outs.run_req) |-> $past(start_press));

   assert_stop_keeps_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_lvl && !oc && !uv && outs.run_req && outs.main_en) |=>
      (!outs.run_req && outs.main_en));

   assert_enable_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(outs.main_en) |-> ($past(low_ref) || $past(oc) || $past(uv)));

   assert_oc_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oc |=> (outs.rect_inhibit && outs.bridge_all_on && outs.commut_inhibit &&
              !outs.bridge_block && !outs.run_req && !outs.main_en));

   assert_uv_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (uv && !oc && !outs.bridge_all_on) |=> (outs.rect_inhibit && outs.bridge_block &&
              outs.commut_inhibit && !outs.bridge_all_on && !outs.run_req && !outs.main_en));

   assert_oc_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (outs.bridge_all_on && uv) |=> outs.bridge_all_on);

   assert_hold_keeps_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SUP_TRIP && !hold_done) |=> (state == SUP_TRIP));

endmodule

// File: rtl/drv_run_supervisor.sv
module drv_run_supervisor
   import drvsup_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned HOLD_US    = 1000,
   parameter bit          START_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_btn,
   input  logic stop_btn,
   input  logic oc_trip,
   input  logic uv_trip,
   input  logic near_zero_ref,
   output logic run_req,
   output logic main_en,
   output logic rect_inhibit,
   output logic bridge_all_on,
   output logic bridge_block,
   output logic commut_inhibit
);
   localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int unsigned HOLD_CYC   = CYC_PER_US * HOLD_US;

   generate
      if (CYC_PER_US < 1) begin : g_bad_clk
         $error("drv_run_supervisor: CLK_HZ must be at least 1 MHz");
      end
      if (HOLD_US < 1) begin : g_bad_us
         $error("drv_run_supervisor: HOLD_US must be at least 1");
      end
   endgenerate

   logic     start_press;
   logic     hold_done;
   sup_out_t o;

   drvsup_press #(.EDGE_MODE(START_EDGE)) u_press (
      .clk   (clk),
      .rst_n (rst_n),
      .btn   (start_btn),
      .press (start_press)
   );

   drvsup_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault   (oc_trip | uv_trip),
      .expired (hold_done)
   );

   drvsup_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_press (start_press),
      .stop_lvl    (stop_btn),
      .oc          (oc_trip),
      .uv          (uv_trip),
      .low_ref     (near_zero_ref),
      .hold_done   (hold_done),
      .outs        (o)
   );

   assign run_req        = o.run_req;
   assign main_en        = o.main_en;
   assign rect_inhibit   = o.rect_inhibit;
   assign bridge_all_on  = o.bridge_all_on;
   assign bridge_block   = o.bridge_block;
   assign commut_inhibit = o.commut_inhibit;

endmodule

// File: tb/drv_run_supervisor_test.sv
module drv_run_supervisor_test;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_btn = 1'b0, stop_btn = 1'b0, oc_trip = 1'b0, uv_trip = 1'b0, near_zero_ref = 1'b0;
   logic run_req, main_en, rect_inhibit, bridge_all_on, bridge_block, commut_inhibit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [5:0] P_IDLE = 6'b000000;
   localparam logic [5:0] P_ARM  = 6'b100000;
   localparam logic [5:0] P_RUN  = 6'b110000;
   localparam logic [5:0] P_RAMP = 6'b010000;
   localparam logic [5:0] P_OC   = 6'b001101;
   localparam logic [5:0] P_UV   = 6'b001011;

   always #10 clk = ~clk;

   drv_run_supervisor #(.CLK_HZ(1_000_000), .HOLD_US(H), .START_EDGE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .stop_btn(stop_btn),
      .oc_trip(oc_trip), .uv_trip(uv_trip), .near_zero_ref(near_zero_ref),
      .run_req(run_req), .main_en(main_en), .rect_inhibit(rect_inhibit),
      .bridge_all_on(bridge_all_on), .bridge_block(bridge_block),
      .commut_inhibit(commut_inhibit)
   );

   wire [5:0] outs = {run_req, main_en, rect_inhibit, bridge_all_on, bridge_block, commut_inhibit};

   task automatic chk(input string tag, input logic [5:0] exp);
      checks++;
      if (outs !== exp) begin
         errors++;
         $display("FAIL %s got=%b exp=%b t=%0t", tag, outs, exp, $time);
      end
   endtask

   // one clock edge with the given inputs, sampled 2 ns after the edge
   task automatic cyc(input logic s, input logic p, input logic o, input logic u, input logic l);
      @(negedge clk);
      start_btn = s; stop_btn = p; oc_trip = o; uv_trip = u; near_zero_ref = l;
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start_btn = 0; stop_btn = 0; oc_trip = 0; uv_trip = 0; near_zero_ref = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic go_run();
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1 chk("R1 reset", P_IDLE);

      // normal start sequence
      cyc(1, 0, 0, 0, 0); chk("R2 arm", P_ARM);
      cyc(0, 0, 0, 0, 0); chk("R2 run", P_RUN);
      cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); chk("R3 sealed", P_RUN);
      cyc(0, 0, 0, 0, 1); chk("R3 low ref ignored", P_RUN);

      // stop and ramp
      cyc(0, 1, 0, 0, 0); chk("R4 stop", P_RAMP);
      cyc(0, 0, 0, 0, 0); chk("R5 ramp holds", P_RAMP);
      cyc(1, 0, 0, 0, 0); chk("R6 restart", P_RUN);
      cyc(0, 0, 0, 0, 0); chk("R6 run kept", P_RUN);
      cyc(1, 1, 0, 0, 0); chk("R4 stop wins", P_RAMP);
      cyc(0, 0, 0, 0, 0); chk("R5 ramp", P_RAMP);
      cyc(0, 0, 0, 0, 1); chk("R5 release", P_IDLE);
      cyc(0, 0, 0, 0, 0); chk("R5 idle", P_IDLE);

      // fault combinations from running
      for (int f = 1; f < 4; f++) begin
         do_reset();
         go_run();
         cyc(0, 0, f[1], f[0], 0);
         if (f[1]) chk(f == 3 ? "R9 both" : "R7 oc", P_OC);
         else      chk("R8 uv", P_UV);
         cyc(1, 0, 0, 0, 0);
         chk("R10 press in hold", f[1] ? P_OC : P_UV);
      end

      // fault from ramp and idle
      do_reset(); go_run(); cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 1, 0, 0); chk("R7 oc in ramp", P_OC);
      do_reset();
      cyc(0, 0, 0, 1, 0); chk("R8 uv idle", P_UV);

      // escalation and non-downgrade
      cyc(0, 0, 1, 0, 0); chk("R9 uv to oc", P_OC);
      cyc(0, 0, 0, 1, 0); chk("R9 oc kept", P_OC);
      cyc(0, 0, 0, 0, 0); chk("R9 oc latched", P_OC);

      // hold window sweep
      for (int k = 1; k <= H + 2; k++) begin
         do_reset();
         cyc(0, 0, 1, 0, 0);
         for (int j = 1; j < k; j++) cyc(0, 0, 0, 0, 0);
         cyc(1, 0, 0, 0, 0);
         if (k >= H + 1) chk("R11 clear after hold", P_ARM);
         else            chk("R10 ignored in hold", P_OC);
      end
      cyc(0, 0, 0, 0, 0); chk("R11 runs on", P_RUN);

      // stop blocks clearing
      do_reset();
      cyc(0, 0, 0, 1, 0);
      for (int j = 0; j < H + 2; j++) cyc(0, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 0); chk("R11 stop blocks clear", P_UV);

      // held start does not clear
      do_reset(); go_run();
      cyc(0, 0, 1, 0, 0);
      cyc(1, 0, 0, 0, 0);
      for (int j = 0; j < H + 3; j++) cyc(1, 0, 0, 0, 0);
      chk("R12 held start", P_OC);
      cyc(0, 0, 0, 0, 0); chk("R12 release", P_OC);
      cyc(1, 0, 0, 0, 0); chk("R12 new press", P_ARM);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule